// File: doc/BRIEF.md
# Binary-Field Polynomial Modular Exponentiator

This block raises a polynomial g(x) to an unsigned integer power k and reduces the result modulo a polynomial f(x). All coefficients are in GF(2). The modulus is supplied at run time, so one instance serves any modulus of degree N. Operand vectors are little-endian in the coefficient sense: bit j holds the coefficient of x^j.

The exponent is consumed least-significant bit first with square-and-multiply. A running square G starts at g, and an accumulator s starts at g or 1, depending on bit 0 of k. For every further bit of k, G is squared modulo f. When that bit is 1, s is multiplied by the new G modulo f. One carry-less multiplier forms every product in a single cycle. A sequential reducer then removes the high part of the product. In each cycle it aligns the modulus under the leading 1 of the dividend and XORs it in. It stops as soon as the dividend's degree drops below N.

A caller pulses `start` while the block is idle. It then waits for the one-cycle `done` pulse, at which point `res` holds the residue.

Top module: `gf2_modexp`

## Requirements
- R1: With k = 0 the result is the polynomial 1 (res = 1, only bit 0 set), and `done` rises in the cycle after `start` is accepted.
- R2: Bit j of `g_in`, `f_in` and `res` is the coefficient of x^j. `f_in` is N+1 bits wide with bit N set to 1. For any k up to 2^KW-1, `res` equals g^k mod f.
- R3: With k = 1 the result is `g_in` unchanged, and `done` rises in the cycle after `start` is accepted.
- R4: With f_in = 1000001011 (binary, MSB first) and g_in = 011010111, the results are 011010111 for k=1, 000101101 for k=2, 110111010 for k=3, and 010111110 for k=22.
- R5: `done` is high for exactly one cycle. `busy` is high from the cycle after an accepted `start` through the `done` cycle.
- R6: A `start` raised while `busy` is high is ignored: the running operation's result is unchanged and no extra `done` follows.
- R7: `g_in`, `f_in` and `k_in` are captured when `start` is accepted. Changing them while busy has no effect on the result.
- R8: `res` holds its value after `done` until the next accepted `start`.
- R9: For the operands of R4, every k from 1 to 63 yields the same residue as repeated multiplication by g modulo f.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted only when not busy) |
| g_in | input | N | Base polynomial, degree below N |
| f_in | input | N+1 | Modulus polynomial, bit N must be 1 |
| k_in | input | KW | Unsigned exponent |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse, result valid |
| res | output | N | Residue g^k mod f |

## Verification
The bench targets exponents whose top bit is isolated, such as 1, 2, 22 and all-ones. A controller that mishandles the final bit either drops the last multiply or runs one square too many, so these cases return the wrong residue.

The k = 0 and k = 1 cases expose an accumulator that is initialised wrongly or a missing early exit. Those faults show up as a wrong value or a late `done`.

The bench also changes the inputs and pulses `start` in the middle of an operation. A design that re-samples its operands, or restarts, then returns a value for the wrong operands or emits a second `done`.

Random moduli with dense high coefficients exercise the reducer's degree test. A reducer that stops one step early leaves residue bits above degree N-1 and produces wrong values.

// File: rtl/gf2_modexp_pkg.sv
package gf2_modexp_pkg;
   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_SQ_ISSUE = 3'd1,
      ST_SQ_WAIT  = 3'd2,
      ST_MU_ISSUE = 3'd3,
      ST_MU_WAIT  = 3'd4,
      ST_DONE     = 3'd5
   } ctl_state_t;
endpackage

// File: rtl/gf2_clmul.sv
module gf2_clmul #(
   parameter int N = 9
) (
   input  logic [N-1:0]   a,
   input  logic [N-1:0]   b,
   output logic [2*N-2:0] p
);
   localparam int PW = 2*N - 1;

   logic [PW-1:0] part [N];

   for (genvar i = 0; i < N; i++) begin : g_part
      assign part[i] = b[i] ? ({{(PW-N){1'b0}}, a} << i) : '0;
   end

   always_comb begin
      p = '0;
      for (int i = 0; i < N; i++) p = p ^ part[i];
   end
endmodule

// File: rtl/gf2_reducer.sv
module gf2_reducer #(
   parameter int N = 9
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [2*N-2:0] dividend,
   input  logic [N:0]     modulus,
   output logic           fin,
   output logic [N-1:0]   rem
);
   localparam int PW = 2*N - 1;
   localparam int HW = N - 1;
   localparam int LW = (HW > 1) ? $clog2(HW) : 1;

   logic [PW-1:0] dvd;
   logic          act;
   logic          hit;
   logic [LW-1:0] lead;
   logic [PW-1:0] f_ext;
   logic [PW-1:0] f_al;

   always_comb begin
      hit  = 1'b0;
      lead = '0;
      for (int i = 0; i < HW; i++) begin
         if (dvd[N+i]) begin
            hit  = 1'b1;
            lead = LW'(i);
         end
      end
   end

   assign f_ext = {{(PW-N-1){1'b0}}, modulus};
   assign f_al  = f_ext << lead;
   assign rem   = dvd[N-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dvd <= '0;
         act <= 1'b0;
         fin <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (load) begin
            dvd <= dividend;
            act <= 1'b1;
         end else if (act) begin
            if (hit) begin
               dvd <= dvd ^ f_al;
            end else begin
               act <= 1'b0;
               fin <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/gf2_modexp.sv
module gf2_modexp
   import gf2_modexp_pkg::*;
#(
   parameter int N  = 9,
   parameter int KW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [N-1:0]  g_in,
   input  logic [N:0]    f_in,
   input  logic [KW-1:0] k_in,
   output logic          busy,
   output logic          done,
   output logic [N-1:0]  res
);
   localparam int PW = 2*N - 1;
   localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

   if (N < 2) begin : g_bad_n
      $error("gf2_modexp: N must be at least 2");
   end
   if (KW < 1) begin : g_bad_kw
      $error("gf2_modexp: KW must be at least 1");
   end

   ctl_state_t    st;
   logic [N-1:0]  g_run;
   logic [N-1:0]  s_acc;
   logic [N:0]    f_reg;
   logic [KW-1:0] k_sh;
   logic [N-1:0]  mul_b;
   logic [PW-1:0] prod;
   logic          red_load;
   logic          red_fin;
   logic [N-1:0]  red_rem;
   logic          last_bit;

   assign mul_b    = (st == ST_SQ_ISSUE) ? g_run : s_acc;
   assign red_load = (st == ST_SQ_ISSUE) || (st == ST_MU_ISSUE);
   assign last_bit = ((k_sh >> 1) == '0);

   gf2_clmul #(.N(N)) u_mul (
      .a (g_run),
      .b (mul_b),
      .p (prod)
   );

   gf2_reducer #(.N(N)) u_red (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (red_load),
      .dividend (prod),
      .modulus  (f_reg),
      .fin      (red_fin),
      .rem      (red_rem)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         g_run <= '0;
         s_acc <= '0;
         f_reg <= '0;
         k_sh  <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (start) begin
                  f_reg <= f_in;
                  g_run <= g_in;
                  k_sh  <= k_in >> 1;
                  s_acc <= k_in[0] ? g_in : ONE;
                  st    <= ((k_in >> 1) == '0) ? ST_DONE : ST_SQ_ISSUE;
               end
            end
            ST_SQ_ISSUE: st <= ST_SQ_WAIT;
            ST_SQ_WAIT: begin
               if (red_fin) begin
                  g_run <= red_rem;
                  if (k_sh[0]) begin
                     st <= ST_MU_ISSUE;
                  end else begin
                     k_sh <= k_sh >> 1;
                     st   <= last_bit ? ST_DONE : ST_SQ_ISSUE;
                  end
               end
            end
            ST_MU_ISSUE: st <= ST_MU_WAIT;
            ST_MU_WAIT: begin
               if (red_fin) begin
                  s_acc <= red_rem;
                  k_sh  <= k_sh >> 1;
                  st    <= last_bit ? ST_DONE : ST_SQ_ISSUE;
               end
            end
            ST_DONE: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy = (st != ST_IDLE);
   assign done = (st == ST_DONE);
   assign res  = s_acc;
endmodule

// File: rtl/gf2_modexp_chk.sv
module gf2_modexp_chk #(
   parameter int N  = 9,
   parameter int KW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic [N-1:0]  g_in,
   input logic [KW-1:0] k_in,
   input logic          busy,
   input logic          done,
   input logic [N-1:0]  res
);
   AST_ZERO_EXP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy && (k_in == '0) |=> done && (res == N'(1))); // R1
   AST_UNIT_EXP_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy && (k_in == KW'(1)) |=> done && (res == $past(g_in))); // R3
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R5
   AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy); // R5
   AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy |=> busy); // R5
   AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !done |=> busy); // R6
   AST_RES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !start |=> $stable(res)); // R8
endmodule

bind gf2_modexp gf2_modexp_chk #(.N(N), .KW(KW)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .start (start),
   .g_in  (g_in),
   .k_in  (k_in),
   .busy  (busy),
   .done  (done),
   .res   (res)
);

// File: tb/gf2_modexp_test.sv
module gf2_modexp_test;
   localparam int N  = 9;
   localparam int KW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [N-1:0]  g_in = '0;
   logic [N:0]    f_in = '0;
   logic [KW-1:0] k_in = '0;
   logic          busy, done;
   logic [N-1:0]  res;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   gf2_modexp #(.N(N), .KW(KW)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .g_in(g_in), .f_in(f_in),
      .k_in(k_in), .busy(busy), .done(done), .res(res)
   );

   function automatic logic [N-1:0] ref_mulmod(input logic [N-1:0] a,
                                               input logic [N-1:0] b,
                                               input logic [N:0] f);
      logic [N:0] acc = '0;
      for (int j = N-1; j >= 0; j--) begin
         acc = acc << 1;
         if (acc[N]) acc = acc ^ f;
         if (b[j]) acc = acc ^ {1'b0, a};
      end
      return acc[N-1:0];
   endfunction

   function automatic logic [N-1:0] ref_pow(input logic [N-1:0] g,
                                            input logic [N:0] f,
                                            input int k);
      logic [N-1:0] r = N'(1);
      for (int i = 0; i < k; i++) r = ref_mulmod(r, g, f);
      return r;
   endfunction

   task automatic check(input string tag, input logic [N-1:0] act,
                        input logic [N-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic check_bit(input string tag, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic run_op(input logic [N-1:0] g, input logic [N:0] f,
                         input logic [KW-1:0] k, input bit disturb,
                         output logic [N-1:0] r, output int lat);
      @(negedge clk);
      g_in = g; f_in = f; k_in = k; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < 5000) begin
         if (disturb && lat == 2) begin
            start = 1'b1;
            g_in  = ~g;
            f_in  = {1'b1, ~f[N-1:0]};
            k_in  = ~k;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         lat++;
      end
      start = 1'b0;
      r = res;
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL R5: done never seen, actual 0 expected 1");
      end
   endtask

   localparam logic [N:0]   F_EX = 10'b1000001011;
   localparam logic [N-1:0] G_EX = 9'b011010111;

   initial begin
      #(10 * 150000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [N-1:0] r;
      int lat;
      int seed_sink;
      seed_sink = int'($urandom(32'h5eed));

      repeat (3) @(negedge clk);
      check_bit("reset busy", busy, 1'b0);
      check_bit("reset done", done, 1'b0);
      rst_n = 1'b1;

      // R1: k = 0
      run_op(G_EX, F_EX, 8'd0, 1'b0, r, lat);
      check("R1 k=0 value", r, N'(1));
      check("R1 k=0 latency", N'(lat), N'(1));

      // R3: k = 1
      run_op(9'b101100111, F_EX, 8'd1, 1'b0, r, lat);
      check("R3 k=1 value", r, 9'b101100111);
      check("R3 k=1 latency", N'(lat), N'(1));

      // R4: literal values
      run_op(G_EX, F_EX, 8'd1, 1'b0, r, lat);  check("R4 k=1", r, 9'b011010111);
      run_op(G_EX, F_EX, 8'd2, 1'b0, r, lat);  check("R4 k=2", r, 9'b000101101);
      run_op(G_EX, F_EX, 8'd3, 1'b0, r, lat);  check("R4 k=3", r, 9'b110111010);
      run_op(G_EX, F_EX, 8'd22, 1'b0, r, lat); check("R4 k=22", r, 9'b010111110);

      // R9: full sweep against repeated multiplication
      for (int k = 1; k < 64; k++) begin
         run_op(G_EX, F_EX, KW'(k), 1'b0, r, lat);
         check($sformatf("R9 k=%0d", k), r, ref_pow(G_EX, F_EX, k));
      end

      // R6 / R7: start and input changes while busy
      run_op(G_EX, F_EX, 8'd200, 1'b1, r, lat);
      check("R6 R7 disturbed op", r, ref_pow(G_EX, F_EX, 200));
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check_bit("R6 no extra done", done, 1'b0);
      end

      // R8: result held after done while inputs move
      g_in = 9'h1aa; f_in = 10'h3ff; k_in = 8'h55;
      repeat (3) @(negedge clk);
      check("R8 result held", res, ref_pow(G_EX, F_EX, 200));

      // R2: edge exponents and random operands
      run_op(9'h1ff, 10'h211, 8'hff, 1'b0, r, lat);
      check("R2 k=255", r, ref_pow(9'h1ff, 10'h211, 255));
      run_op(9'h000, F_EX, 8'd5, 1'b0, r, lat);
      check("R2 zero base", r, 9'h000);
      for (int i = 0; i < 40; i++) begin
         logic [N-1:0]  g;
         logic [N:0]    f;
         logic [KW-1:0] k;
         g = N'($urandom);
         f = {1'b1, N'($urandom)};
         k = KW'($urandom);
         run_op(g, f, k, 1'b0, r, lat);
         check($sformatf("R2 rand g=%b f=%b k=%0d", g, f, k), r, ref_pow(g, f, int'(k)));
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule